// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. An active-low start strobe begins a conversion; from then on the block presents a trial code to an external DAC and reads back one comparator bit each clock. It works from the most significant bit down to the least, keeping a bit when the comparator reports that the input is at or above the trial level. After the last decision it spends one clock copying the finished code into an output register and drops its conversion-active flag.

The output register feeds a parallel bus. The bus is modelled as an enable signal plus data. It is enabled only while both the select and the read inputs are low, and it reads as zero otherwise. The register is written only at the end of a conversion, so the bus cannot change while a conversion runs.

A new falling edge on the start strobe during a conversion abandons that conversion and starts again from the top bit. The level of the strobe at the moment the result is latched is reported as a fast-mode flag. The first result after reset is marked as a throw-away sample by a status bit.

Top module: `sar_seq`

## Requirements
- R1: While reset is high and after it, before any conversion, `conv_active`, `fast_mode` and `dummy_flag` are 0, and the output register holds 0.
- R2: A high-to-low change of `start_n`, seen between two rising clock edges, sets `conv_active` at the next edge. At that edge `trial_code` becomes the top bit alone (2048 for 12 bits).
- R3: The result is the straight binary code of the input: the largest code not above the input level. An input code of v yields bus data v for every v from 0 to 4095.
- R4: `conv_active` stays high for exactly NBITS+1 rising edges: 12 bit decisions plus one latch clock.
- R5: A new falling edge of `start_n` while `conv_active` is high restarts the search with `trial_code` at the top bit. `conv_active` stays high throughout, and only the restarted conversion yields a result.
- R6: `bus_oe` is 1 only while `bus_sel_n` and `bus_read_n` are both 0. Whenever `bus_oe` is 0, `bus_data` is all zeros. Whenever it is 1, `bus_data` carries the output register.
- R7: The output register, and so `bus_data` while enabled, does not change while `conv_active` is high. It changes only on the edge where `conv_active` falls.
- R8: `fast_mode` takes the level of `start_n` at the latch edge. It is 1 (high-speed) if the strobe has returned high by then, and 0 if the strobe is still low.
- R9: `dummy_flag` is 1 after the first result following reset and 0 after every later result.
- R10: `start_n` held low after a conversion completes does not start another conversion. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Convert-start strobe, active low, falling edge starts |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the trial level |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_read_n | input | 1 | Bus read, active low |
| trial_code | output | NBITS | Trial code driven to the DAC |
| conv_active | output | 1 | High for the whole conversion |
| bus_oe | output | 1 | Bus output enable (models the driven, not high-impedance, state) |
| bus_data | output | NBITS | Result register gated by the enable |
| fast_mode | output | 1 | Strobe was high at the latch edge |
| dummy_flag | output | 1 | Last result is the first after reset |

## Verification
The bench builds the block with its default resolution of 12 bits. This makes both code extremes reachable: 0 and 4095. It also reaches the step across the top bit (2047 against 2048) and the exact 13-clock window in which the strobe level decides the mode. Strobe release times of 13 and 14 clocks after the fall sit on either side of the latch edge. A restart injected in the middle of the search shows that the partial code is discarded.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Phase of the bit search
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRY   = 2'd1,
    PH_LATCH = 2'd2
  } sar_phase_e;

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  output logic start_evt
);

  logic start_n_q;

  always_ff @(posedge clk) begin
    if (rst) start_n_q <= 1'b1;
    else     start_n_q <= start_n;
  end

  // falling edge of the active-low strobe
  assign start_evt = start_n_q & ~start_n;

endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_evt,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] trial_code,
  output logic             conv_active,
  output logic             latch_evt
);

  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  sar_phase_e      phase;
  logic [IW-1:0]   idx;
  logic [NBITS-1:0] code;

  // Decide bit idx, then raise the next lower trial bit
  function automatic logic [NBITS-1:0] resolve_bit(
    input logic [NBITS-1:0] cur,
    input logic [IW-1:0]    pos,
    input logic             keep
  );
    logic [NBITS-1:0] r;
    r = cur;
    if (!keep) r[pos] = 1'b0;
    if (pos != '0) r[pos - 1'b1] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
      code  <= '0;
    end else if (start_evt) begin
      phase <= PH_TRY;
      idx   <= IW'(NBITS - 1);
      code  <= TOP_BIT;
    end else begin
      case (phase)
        PH_TRY: begin
          code <= resolve_bit(code, idx, cmp_ge);
          if (idx == '0) phase <= PH_LATCH;
          else           idx   <= idx - 1'b1;
        end
        PH_LATCH: phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign trial_code  = code;
  assign conv_active = (phase != PH_IDLE);
  assign latch_evt   = (phase == PH_LATCH) && !start_evt;

endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_evt,
  input  logic [NBITS-1:0] final_code,
  input  logic             start_n,
  input  logic             bus_sel_n,
  input  logic             bus_read_n,
  output logic [NBITS-1:0] res_q,
  output logic             bus_oe,
  output logic [NBITS-1:0] bus_data,
  output logic             fast_mode,
  output logic             dummy_flag
);

  logic seen_result;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q       <= '0;
      fast_mode   <= 1'b0;
      dummy_flag  <= 1'b0;
      seen_result <= 1'b0;
    end else if (latch_evt) begin
      res_q       <= final_code;
      fast_mode   <= start_n;
      dummy_flag  <= ~seen_result;
      seen_result <= 1'b1;
    end
  end

  assign bus_oe   = ~bus_sel_n & ~bus_read_n;
  assign bus_data = bus_oe ? res_q : '0;

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             cmp_ge,
  input  logic             bus_sel_n,
  input  logic             bus_read_n,
  output logic [NBITS-1:0] trial_code,
  output logic             conv_active,
  output logic             bus_oe,
  output logic [NBITS-1:0] bus_data,
  output logic             fast_mode,
  output logic             dummy_flag
);

  // Internal events, named for the checker
  logic             start_evt;
  logic             latch_evt;
  logic [NBITS-1:0] res_q;

  sar_start_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .start_n   (start_n),
    .start_evt (start_evt)
  );

  sar_search #(.NBITS(NBITS)) u_search (
    .clk         (clk),
    .rst         (rst),
    .start_evt   (start_evt),
    .cmp_ge      (cmp_ge),
    .trial_code  (trial_code),
    .conv_active (conv_active),
    .latch_evt   (latch_evt)
  );

  sar_out_reg #(.NBITS(NBITS)) u_out (
    .clk        (clk),
    .rst        (rst),
    .latch_evt  (latch_evt),
    .final_code (trial_code),
    .start_n    (start_n),
    .bus_sel_n  (bus_sel_n),
    .bus_read_n (bus_read_n),
    .res_q      (res_q),
    .bus_oe     (bus_oe),
    .bus_data   (bus_data),
    .fast_mode  (fast_mode),
    .dummy_flag (dummy_flag)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start_n,
  input logic             start_evt,
  input logic             latch_evt,
  input logic             conv_active,
  input logic [NBITS-1:0] trial_code,
  input logic [NBITS-1:0] res_q,
  input logic             bus_sel_n,
  input logic             bus_read_n,
  input logic             bus_oe,
  input logic [NBITS-1:0] bus_data,
  input logic             fast_mode
);

  localparam int CW = $clog2(NBITS + 3) + 1;
  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [CW-1:0] act_cnt;

  always_ff @(posedge clk) begin
    if (rst)              act_cnt <= '0;
    else if (start_evt)   act_cnt <= '0;
    else if (conv_active) act_cnt <= act_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!conv_active && res_q == '0 && !fast_mode));

  assert_start_top_R2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (conv_active && trial_code == TOP_BIT));

  assert_active_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_active) |-> (act_cnt == CW'(NBITS + 1)));

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_n || bus_read_n) |-> (!bus_oe && bus_data == '0));

  assert_gate_on_R6: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (bus_data == res_q));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    conv_active |=> (!conv_active || $stable(res_q)));

  assert_mode_R8: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> (fast_mode == $past(start_n)));

endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_n     (start_n),
  .start_evt   (start_evt),
  .latch_evt   (latch_evt),
  .conv_active (conv_active),
  .trial_code  (trial_code),
  .res_q       (res_q),
  .bus_sel_n   (bus_sel_n),
  .bus_read_n  (bus_read_n),
  .bus_oe      (bus_oe),
  .bus_data    (bus_data),
  .fast_mode   (fast_mode)
);

// File: tb/sar_seq_test.sv
`timescale 1ns/1ps
module sar_seq_test;

  localparam int NBITS = 12;

  typedef struct {
    logic [NBITS-1:0] code;
    logic             fast;
    logic             dummy;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_n = 1'b1;
  logic bus_sel_n = 1'b0;
  logic bus_read_n = 1'b0;
  logic [NBITS-1:0] vin = '0;
  logic cmp_ge;
  logic [NBITS-1:0] trial_code;
  logic conv_active, bus_oe, fast_mode, dummy_flag;
  logic [NBITS-1:0] bus_data;

  int checks = 0;
  int fails = 0;
  logic done_once = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  // behavioural comparator against the stored input code
  assign cmp_ge = (vin >= trial_code);

  sar_seq #(.NBITS(NBITS)) uut (
    .clk(clk), .rst(rst), .start_n(start_n), .cmp_ge(cmp_ge),
    .bus_sel_n(bus_sel_n), .bus_read_n(bus_read_n),
    .trial_code(trial_code), .conv_active(conv_active),
    .bus_oe(bus_oe), .bus_data(bus_data),
    .fast_mode(fast_mode), .dummy_flag(dummy_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Monitor: pops expected results when conversion ends
  logic prev_act = 1'b0;
  logic prev_start = 1'b1;
  logic [NBITS-1:0] prev_data = '0;
  int act_len = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_act = 1'b0;
      act_len = 0;
    end else begin
      if (conv_active) begin
        if (!start_n && prev_start) act_len = 1;
        else act_len++;
        if (prev_act) check("R7 bus frozen", bus_data, prev_data);
      end
      if (prev_act && !conv_active) begin
        check("R4 active length", act_len, NBITS + 1);
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 unexpected result actual=%0d expected=none", bus_data);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R3 result code", bus_data, e.code);
          check("R8 mode flag", fast_mode, e.fast);
          check("R9 dummy flag", dummy_flag, e.dummy);
        end
        act_len = 0;
      end
      prev_act = conv_active;
      prev_data = bus_data;
    end
    prev_start = start_n;
  end

  // Driver: one conversion, strobe released at tick k (k > 16: after completion)
  task automatic convert(input logic [NBITS-1:0] v, input int k);
    exp_t e;
    tick();
    vin = v;
    start_n = 1'b0;
    e.code = v; e.fast = (k <= NBITS + 1); e.dummy = !done_once;
    sb.push_back(e);
    done_once = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      tick();
      if (i == 1) begin
        check("R2 active after fall", conv_active, 1);
        check("R2 top trial bit", trial_code, 12'h800);
      end
      if (i == k) start_n = 1'b1;
    end
    if (!start_n) begin
      check("R10 no retrigger while held low", conv_active, 0);
      start_n = 1'b1;
    end
  endtask

  task automatic abort_run(input logic [NBITS-1:0] va, input logic [NBITS-1:0] vb);
    exp_t e;
    tick();
    vin = va;
    start_n = 1'b0;
    repeat (5) tick();
    start_n = 1'b1;
    tick();
    check("R5 still active before restart", conv_active, 1);
    vin = vb;
    start_n = 1'b0;
    e.code = vb; e.fast = 1'b0; e.dummy = !done_once;
    sb.push_back(e);
    done_once = 1'b1;
    tick();
    check("R5 active after restart", conv_active, 1);
    check("R5 restart from top bit", trial_code, 12'h800);
    repeat (15) tick();
    check("R5 finished once", conv_active, 0);
    start_n = 1'b1;
  endtask

  task automatic do_reset();
    tick();
    rst = 1'b1;
    tick();
    tick();
    check("R1 active in reset", conv_active, 0);
    check("R1 fast in reset", fast_mode, 0);
    check("R1 dummy in reset", dummy_flag, 0);
    check("R1 register in reset", bus_data, 0);
    rst = 1'b0;
    done_once = 1'b0;
    tick();
    check("R1 idle after reset", conv_active, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NBITS-1:0] lcg;
    do_reset();
    convert(12'd0, 3);        // R9 dummy, R8 fast
    convert(12'd4095, 20);    // R8 slow, R10
    convert(12'd2048, 13);    // R8 boundary fast
    convert(12'd2047, 14);    // R8 boundary slow
    convert(12'd1, 5);
    abort_run(12'd3000, 12'd1234);
    convert(12'hA5C, 4);
    // R6 bus gating
    tick();
    bus_sel_n = 1'b1; bus_read_n = 1'b0; #1;
    check("R6 oe off sel high", bus_oe, 0);
    check("R6 data zero sel high", bus_data, 0);
    bus_sel_n = 1'b0; bus_read_n = 1'b1; #1;
    check("R6 oe off read high", bus_oe, 0);
    check("R6 data zero read high", bus_data, 0);
    bus_sel_n = 1'b1; bus_read_n = 1'b1; #1;
    check("R6 oe off both high", bus_oe, 0);
    bus_sel_n = 1'b0; bus_read_n = 1'b0; #1;
    check("R6 oe on both low", bus_oe, 1);
    check("R6 data on both low", bus_data, 12'hA5C);
    lcg = 12'h3B1;
    for (int n = 0; n < 8; n++) begin
      lcg = lcg * 12'd1103 + 12'd977;
      convert(lcg, (n % 2 == 0) ? 6 : 18);
    end
    do_reset();
    convert(12'd777, 20);     // R9 dummy again after reset
    convert(12'd778, 2);
    repeat (3) tick();
    check("R3 all results seen", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule